// File: doc/BRIEF.md
# Fixed-Point Variable Node Processor

This block handles one variable node of degree `DEG` in an iterative LDPC decoder. It takes one beat of `DEG` signed fixed-point LLRs. Lane 0 carries the channel observation and lanes 1 to `DEG-1` carry the messages coming back from the connected check nodes. It returns `DEG` extrinsic messages. Message `i` is the sum of every lane except lane `i`.

The sums come from a forward (prefix) chain and a backward (suffix) chain of two-input adders. No subtraction of a lane from a total is used. Every adder saturates at the internal word width of `INT_Y + FRAC_Z` bits. Each extrinsic result is then clipped to a narrower `CLIP_X + FRAC_Z` bit word before it goes back to the check nodes. The saturated sum of all lanes is also returned as the a posteriori LLR, together with its sign as a hard decision. The default format uses a 6-bit operand: 5 integer bits including the sign, and 1 fraction bit.

Data enters and leaves through valid/ready streams. Each accepted beat is held in a single output register.
- A beat is taken on any edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty, or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, the output payload stays frozen. During that time no new beat is taken.
- Throughput is one beat per cycle when the consumer never stalls.

Top module: `vnp_fb_core`

## Requirements
- R1: With lanes numbered 0 to DEG-1, define the forward terms F0 = x0 and Fi = sat(xi + F(i-1)), and the backward terms B(DEG-1) = x(DEG-1) and Bi = sat(xi + B(i+1)). The unclipped extrinsic value for lane 0 is B1, for lane DEG-1 it is F(DEG-2), and for every other lane i it is sat(F(i-1) + B(i+1)).
- R2: Every addition saturates to the signed range of INT_Y+FRAC_Z bits, [-2^(W-1), 2^(W-1)-1]. It never wraps.
- R3: Each extrinsic output is the R1 value clipped to the signed range of CLIP_X+FRAC_Z bits. The sign of the output always equals the sign of the unclipped value. Lane i sits at out_ext bits [i*OW +: OW].
- R4: out_app equals F(DEG-1), the saturating sum of all lanes. out_hard is 1 exactly when out_app is negative.
- R5: While rst_n is low and right after reset, out_valid is 0 and in_ready is 1.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and all output payload bits stay unchanged on the next cycle.
- R7: A beat accepted on one edge appears with out_valid set after that edge. in_ready is high whenever out_valid is 0 or out_ready is 1.
- R8: Input data presented while in_valid is 0 is ignored. Output beats come out in acceptance order, with none lost or duplicated.
- R9: For DEG = 2, lane 0's output is the clipped lane 1 input and lane 1's output is the clipped lane 0 input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_llr | input | DEG*(INT_Y+FRAC_Z) | Packed input LLRs, lane i at [i*W +: W], lane 0 is the channel LLR |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the beat |
| out_ext | output | DEG*(CLIP_X+FRAC_Z) | Packed clipped extrinsic messages |
| out_app | output | INT_Y+FRAC_Z | Saturated a posteriori LLR |
| out_hard | output | 1 | Hard decision, 1 when out_app is negative |

## Verification
On every clock, the assertions check the stream rules:
- a stalled beat stays frozen;
- out_valid drops only after a drain;
- every accepted beat lands in the output register;
- clipping never flips the sign of an extrinsic value.

The arithmetic itself is shown only by the bench. It sweeps every input combination of a degree-4 node with a 4-bit word while applying irregular stalls on both sides. It also sweeps a degree-2 node. The results are compared with an integer model of the saturating prefix/suffix sums and of the clipping. Ordering, loss and the ignoring of data while in_valid is low also show up only in that sweep.

// File: rtl/vnp_pkg.sv
package vnp_pkg;

  typedef enum logic [1:0] {
    SAT_NONE = 2'd0,
    SAT_HI   = 2'd1,
    SAT_LO   = 2'd2
  } sat_kind_e;

  // overflow class of a two's complement add from the three sign bits
  function automatic sat_kind_e sat_classify(input logic sa, input logic sb, input logic sr);
    if (!sa && !sb && sr) return SAT_HI;
    if (sa && sb && !sr)  return SAT_LO;
    return SAT_NONE;
  endfunction

endpackage

// File: rtl/vnp_sat_add.sv
module vnp_sat_add #(
  parameter int W = 6
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);
  import vnp_pkg::*;

  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] raw;

  always_comb begin
    raw = a_i + b_i;
    unique case (sat_classify(a_i[W-1], b_i[W-1], raw[W-1]))
      SAT_HI:  s_o = MAXV;
      SAT_LO:  s_o = MINV;
      default: s_o = raw;
    endcase
  end

endmodule

// File: rtl/vnp_clip.sv
module vnp_clip #(
  parameter int IW = 6,
  parameter int OW = 5
) (
  input  logic [IW-1:0] d_i,
  output logic [OW-1:0] d_o
);

  generate
    if (OW == IW) begin : g_pass
      assign d_o = d_i;
    end else if (OW > IW) begin : g_extend
      assign d_o = {{(OW-IW){d_i[IW-1]}}, d_i};
    end else begin : g_clip
      localparam logic [OW-1:0] MAXV = {1'b0, {(OW-1){1'b1}}};
      localparam logic [OW-1:0] MINV = {1'b1, {(OW-1){1'b0}}};
      logic [IW-OW:0] top_bits;
      logic           fits;
      always_comb begin
        top_bits = d_i[IW-1:OW-1];
        fits     = (&top_bits) | ~(|top_bits);
        if (fits)          d_o = d_i[OW-1:0];
        else if (d_i[IW-1]) d_o = MINV;
        else               d_o = MAXV;
      end
    end
  endgenerate

endmodule

// File: rtl/vnp_out_reg.sv
module vnp_out_reg #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_valid && in_ready) out_data <= in_data;
    end
  end

  // stalled beat must stay put
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // a beat only leaves when the consumer took it
  assert_no_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  // every accepted beat is presented on the next cycle
  assert_accept_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

endmodule

// File: rtl/vnp_fb_core.sv
module vnp_fb_core #(
  parameter int DEG    = 4,
  parameter int INT_Y  = 5,
  parameter int FRAC_Z = 1,
  parameter int CLIP_X = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [DEG*(INT_Y+FRAC_Z)-1:0]  in_llr,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [DEG*(CLIP_X+FRAC_Z)-1:0] out_ext,
  output logic [INT_Y+FRAC_Z-1:0]        out_app,
  output logic                           out_hard
);

  localparam int W  = INT_Y + FRAC_Z;
  localparam int OW = CLIP_X + FRAC_Z;
  localparam int PW = DEG*OW + W + 1;

  logic [W-1:0]  lane [DEG];
  logic [W-1:0]  fwd  [DEG];
  logic [W-1:0]  bwd  [DEG];
  logic [W-1:0]  ext_raw [DEG];
  logic [OW-1:0] ext_clip [DEG];
  logic [DEG*OW-1:0] ext_bus;
  logic [PW-1:0] pay_in;
  logic [PW-1:0] pay_out;

  generate
    for (genvar i = 0; i < DEG; i++) begin : g_lane
      assign lane[i] = in_llr[i*W +: W];

      // prefix chain, R1/R2
      if (i == 0) begin : g_f0
        assign fwd[0] = lane[0];
      end else begin : g_fi
        vnp_sat_add #(.W(W)) f_add_i (.a_i(lane[i]), .b_i(fwd[i-1]), .s_o(fwd[i]));
      end

      // suffix chain, R1/R2
      if (i == DEG-1) begin : g_bl
        assign bwd[i] = lane[i];
      end else begin : g_bi
        vnp_sat_add #(.W(W)) b_add_i (.a_i(lane[i]), .b_i(bwd[i+1]), .s_o(bwd[i]));
      end

      // extrinsic combine, R1/R9
      if (i == 0) begin : g_e0
        assign ext_raw[i] = bwd[1];
      end else if (i == DEG-1) begin : g_el
        assign ext_raw[i] = fwd[DEG-2];
      end else begin : g_ei
        vnp_sat_add #(.W(W)) e_add_i (.a_i(fwd[i-1]), .b_i(bwd[i+1]), .s_o(ext_raw[i]));
      end

      // clip to return width, R3
      vnp_clip #(.IW(W), .OW(OW)) clip_i (.d_i(ext_raw[i]), .d_o(ext_clip[i]));
      assign ext_bus[i*OW +: OW] = ext_clip[i];

      assert_clip_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (ext_clip[i][OW-1] == ext_raw[i][W-1]));
    end
  endgenerate

  // payload: extrinsic bus, a posteriori sum, hard decision (R4)
  assign pay_in = {ext_bus, fwd[DEG-1], fwd[DEG-1][W-1]};

  vnp_out_reg #(.PW(PW)) out_reg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign out_ext  = pay_out[PW-1 -: DEG*OW];
  assign out_app  = pay_out[W:1];
  assign out_hard = pay_out[0];

endmodule

// File: tb/vnp_fb_core_tb_top.sv
module vnp_fb_core_tb_top;

  localparam int BW  = 4;
  localparam int BOW = 3;
  localparam int D4  = 4;
  localparam int N4  = 1 << (D4*BW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // degree-4 instance
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [D4*BW-1:0] in_llr = '0;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [D4*BOW-1:0] out_ext;
  logic [BW-1:0]   out_app;
  logic            out_hard;

  vnp_fb_core #(.DEG(D4), .INT_Y(3), .FRAC_Z(1), .CLIP_X(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_llr(in_llr), .out_valid(out_valid), .out_ready(out_ready),
    .out_ext(out_ext), .out_app(out_app), .out_hard(out_hard));

  // degree-2 instance
  logic            v2_in_valid = 1'b0;
  logic            v2_in_ready;
  logic [2*BW-1:0] v2_llr = '0;
  logic            v2_out_valid;
  logic [2*BOW-1:0] v2_ext;
  logic [BW-1:0]   v2_app;
  logic            v2_hard;

  vnp_fb_core #(.DEG(2), .INT_Y(3), .FRAC_Z(1), .CLIP_X(2)) dut_deg2_i (
    .clk(clk), .rst_n(rst_n), .in_valid(v2_in_valid), .in_ready(v2_in_ready),
    .in_llr(v2_llr), .out_valid(v2_out_valid), .out_ready(1'b1),
    .out_ext(v2_ext), .out_app(v2_app), .out_hard(v2_hard));

  function automatic int sat_w(input int v, input int w);
    int lo = -(1 << (w-1));
    int hi = (1 << (w-1)) - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic int sx(input int v, input int w);
    int m = v & ((1 << w) - 1);
    if (m >= (1 << (w-1))) return m - (1 << w);
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // check one degree-4 output beat against the integer model of vector n
  task automatic check_beat4(input int n);
    int x[D4];
    int f[D4];
    int b[D4];
    int e;
    for (int j = 0; j < D4; j++) x[j] = sx(n >> (j*BW), BW);
    f[0] = x[0];
    for (int j = 1; j < D4; j++) f[j] = sat_w(x[j] + f[j-1], BW);
    b[D4-1] = x[D4-1];
    for (int j = D4-2; j >= 0; j--) b[j] = sat_w(x[j] + b[j+1], BW);
    for (int j = 0; j < D4; j++) begin
      if (j == 0) e = b[1];
      else if (j == D4-1) e = f[D4-2];
      else e = sat_w(f[j-1] + b[j+1], BW);
      e = sat_w(e, BOW);
      chk(sx(int'(out_ext[j*BOW +: BOW]), BOW) == e, "R1/R2/R3 extrinsic",
          sx(int'(out_ext[j*BOW +: BOW]), BOW), e);
    end
    chk(sx(int'(out_app), BW) == f[D4-1], "R4 app", sx(int'(out_app), BW), f[D4-1]);
    chk(out_hard == (f[D4-1] < 0), "R4 hard", int'(out_hard), int'(f[D4-1] < 0));
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin : main
    int sent = 0;
    int got = 0;
    int cyc = 0;
    bit stall_prev = 1'b0;
    logic [D4*BOW-1:0] held_ext = '0;
    logic [BW-1:0] held_app = '0;
    logic held_hard = 1'b0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 reset out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R5 reset in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 after reset out_valid", int'(out_valid), 0);

    // exhaustive degree-4 stream with stalls on both sides
    while (got < N4) begin
      @(negedge clk);
      out_ready = (cyc % 5) != 3;
      in_valid  = (sent < N4) && ((cyc % 7) != 5);
      // R8: garbage on the bus while in_valid is low
      in_llr    = in_valid ? sent[D4*BW-1:0] : (16'hA5C3 ^ cyc[15:0]);
      #1;
      chk(in_ready == (!out_valid || out_ready), "R7 in_ready rule",
          int'(in_ready), int'(!out_valid || out_ready));
      if (stall_prev) begin
        chk(out_valid && out_ext == held_ext && out_app == held_app && out_hard == held_hard,
            "R6 stall hold", int'(out_ext), int'(held_ext));
      end
      if (out_valid && out_ready) begin
        check_beat4(got);  // R8 order: output k must match accepted vector k
        got++;
      end
      stall_prev = out_valid && !out_ready;
      held_ext = out_ext;
      held_app = out_app;
      held_hard = out_hard;
      if (in_valid && in_ready) sent++;
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 no extra beat", int'(out_valid), 0);

    // degree-2 exhaustive sweep, R9
    for (int n = 0; n < (1 << (2*BW)); n++) begin
      int a;
      int bb;
      int s;
      @(negedge clk);
      v2_in_valid = 1'b1;
      v2_llr = n[2*BW-1:0];
      @(negedge clk);
      a = sx(n, BW);
      bb = sx(n >> BW, BW);
      s = sat_w(a + bb, BW);
      chk(v2_out_valid == 1'b1, "R7 deg2 valid", int'(v2_out_valid), 1);
      chk(sx(int'(v2_ext[BOW-1:0]), BOW) == sat_w(bb, BOW), "R9 lane0",
          sx(int'(v2_ext[BOW-1:0]), BOW), sat_w(bb, BOW));
      chk(sx(int'(v2_ext[2*BOW-1:BOW]), BOW) == sat_w(a, BOW), "R9 lane1",
          sx(int'(v2_ext[2*BOW-1:BOW]), BOW), sat_w(a, BOW));
      chk(sx(int'(v2_app), BW) == s, "R2 deg2 app", sx(int'(v2_app), BW), s);
    end
    v2_in_valid = 1'b0;
    finish_run();
  end

endmodule